// File: doc/BRIEF.md
# Unified Reservation Station Array

This block holds instructions that have left in-order issue but cannot yet execute. One pool of entries serves every functional unit type, so a burst of instructions for one unit type can use all the storage instead of stalling on a small private pool. Each entry records an opcode, the reorder buffer tag of its result, and two source operands. Each operand is either a value or the tag of the instruction that will produce it. Entries watch every result broadcast and swap a matching tag for the broadcast value.

Each cycle, every unit type looks for the oldest entry of its own type whose operands are all values. When a unit of that type is free, that entry is sent out with its operands and tag. The entry is released on that same edge, without waiting for the result to come back. A flush empties the whole pool. Issue needs both a free entry here and a free reorder buffer slot, which is signalled on `rob_free_i`. The number of empty entries is always visible to the issue stage.

Top module: `unified_rs`

## Requirements
- R1: After reset, all 8 entries are empty: `free_cnt_o` reads 8, no `disp_valid_o` bit is set, and `issue_ready_o` follows `rob_free_i`.
- R2: An issue is accepted only when `issue_valid_i`, `rob_free_i` and at least one empty entry are all present. `issue_ready_o` is high exactly when an entry is empty and `rob_free_i` is high. An issue offered while `issue_ready_o` is low changes nothing.
- R3: A dispatched instruction carries the opcode, the reorder buffer tag and both operand values it was issued with. Each instruction dispatches exactly once.
- R4: A waiting operand captures the data of any broadcast port whose valid bit is set and whose tag equals the operand tag. Broadcasts with other tags have no effect. The captured entry can dispatch from the cycle after the capture edge, and not in the broadcast cycle itself.
- R5: A broadcast in the same cycle as the issue of an entry waiting on that tag is captured by the new entry. The entry can then dispatch in the next cycle.
- R6: Opcode bit 3 (the MSB) selects the unit type. Value 0 goes to unit type 0 (add), and value 1 goes to unit type 1 (multiply), on that type's dispatch port.
- R7: A dispatch on type t happens only while `unit_free_i[t]` is high. Each type dispatches at most one entry per cycle, and both types can dispatch in the same cycle.
- R8: Among ready entries of the same type, the one issued earliest is dispatched first.
- R9: An entry is released on the clock edge on which it dispatches. `free_cnt_o` rises after that edge with no broadcast needed.
- R10: While `flush_i` is high there is no dispatch and no issue is accepted. After that edge every entry is empty.
- R11: `free_cnt_o` always equals the number of empty entries. After each edge it equals the previous count, minus one for an accepted issue, plus the number of dispatches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Clear all entries |
| issue_valid_i | input | 1 | Issue request |
| issue_op_i | input | 4 | Opcode; MSB selects unit type |
| issue_tag_i | input | 4 | Reorder buffer tag of the result |
| issue_src_rdy_i | input | 2 | Per operand: 1 = value, 0 = tag |
| issue_src_tag_i | input | 2x4 | Producer tag per operand |
| issue_src_val_i | input | 2x32 | Value per operand |
| rob_free_i | input | 1 | Reorder buffer has a free slot |
| issue_ready_o | output | 1 | Issue can be accepted |
| bc_valid_i | input | 2 | Broadcast valid per port |
| bc_tag_i | input | 2x4 | Broadcast tag per port |
| bc_data_i | input | 2x32 | Broadcast data per port |
| unit_free_i | input | 2 | A unit of the type is free |
| disp_valid_o | output | 2 | Dispatch per unit type |
| disp_op_o | output | 2x4 | Dispatched opcode |
| disp_tag_o | output | 2x4 | Dispatched reorder buffer tag |
| disp_a_o | output | 2x32 | First operand |
| disp_b_o | output | 2x32 | Second operand |
| free_cnt_o | output | 4 | Number of empty entries |

## Verification
Issue and result broadcast can land on the same edge. In that case the new entry must take the value directly and not keep waiting for a tag that has already gone by. The bench drives both of a multiply's operand tags on the two broadcast ports in the very cycle the multiply is issued. It then expects that multiply on the multiply port one cycle later, with the broadcast data as its operands. A separate case sends the broadcast one cycle after issue. There the bench confirms that dispatch follows the capture edge and does not come in the broadcast cycle.

// File: rtl/urs_pkg.sv
package urs_pkg;
  typedef enum logic [0:0] {UT_ADD = 1'b0, UT_MUL = 1'b1} unit_t;
  localparam int unsigned NUM_UNIT_TYPES = 2;
endpackage

// File: rtl/urs_entry.sv
module urs_entry #(
  parameter int unsigned OP_W   = 4,
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_BC   = 2
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         flush_i,
  input  logic                         alloc_i,
  input  logic                         clear_i,
  input  logic [OP_W-1:0]              op_i,
  input  logic [TAG_W-1:0]             tag_i,
  input  logic [1:0]                   src_rdy_i,
  input  logic [1:0][TAG_W-1:0]        src_tag_i,
  input  logic [1:0][DATA_W-1:0]       src_val_i,
  input  logic [N_BC-1:0]              bc_valid_i,
  input  logic [N_BC-1:0][TAG_W-1:0]   bc_tag_i,
  input  logic [N_BC-1:0][DATA_W-1:0]  bc_data_i,
  output logic                         valid_o,
  output logic                         ready_o,
  output logic [OP_W-1:0]              op_o,
  output logic [TAG_W-1:0]             tag_o,
  output logic [1:0][DATA_W-1:0]       opnd_o
);
  logic                   valid_q;
  logic [OP_W-1:0]        op_q;
  logic [TAG_W-1:0]       tag_q;
  logic [1:0]             rdy_q, rdy_d, cur_rdy;
  logic [1:0][TAG_W-1:0]  stag_q, cur_tag;
  logic [1:0][DATA_W-1:0] val_q, val_d;

  // wakeup applies to fresh issue operands as well as stored ones
  always_comb begin
    for (int s = 0; s < 2; s++) begin
      cur_rdy[s] = alloc_i ? src_rdy_i[s] : rdy_q[s];
      cur_tag[s] = alloc_i ? src_tag_i[s] : stag_q[s];
      val_d[s]   = alloc_i ? src_val_i[s] : val_q[s];
      rdy_d[s]   = cur_rdy[s];
      for (int b = 0; b < int'(N_BC); b++) begin
        if (!cur_rdy[s] && bc_valid_i[b] && bc_tag_i[b] == cur_tag[s]) begin
          rdy_d[s] = 1'b1;
          val_d[s] = bc_data_i[b];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      op_q    <= '0;
      tag_q   <= '0;
      rdy_q   <= '0;
      stag_q  <= '0;
      val_q   <= '0;
    end else begin
      if (flush_i)      valid_q <= 1'b0;
      else if (alloc_i) valid_q <= 1'b1;
      else if (clear_i) valid_q <= 1'b0;
      if (alloc_i) begin
        op_q   <= op_i;
        tag_q  <= tag_i;
        stag_q <= src_tag_i;
      end
      rdy_q <= rdy_d;
      val_q <= val_d;
    end
  end

  assign valid_o = valid_q;
  assign ready_o = valid_q & (&rdy_q);
  assign op_o    = op_q;
  assign tag_o   = tag_q;
  assign opnd_o  = val_q;
endmodule

// File: rtl/urs_age.sv
module urs_age #(
  parameter int unsigned N = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [N-1:0]   alloc_i,
  output logic [N*N-1:0] older_o
);
  // older_o[i*N+j] set: entry i was issued before entry j
  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      if (i == j) begin : g_diag
        assign older_o[i*N+j] = 1'b0;
      end else begin : g_bit
        logic bit_q;
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni)         bit_q <= 1'b0;
          else if (alloc_i[j]) bit_q <= 1'b1;
          else if (alloc_i[i]) bit_q <= 1'b0;
        end
        assign older_o[i*N+j] = bit_q;
      end
    end
  end
endmodule

// File: rtl/urs_pick.sv
module urs_pick #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0]   cand_i,
  input  logic [N*N-1:0] older_i,
  output logic [N-1:0]   grant_o
);
  logic [N-1:0] blocked;
  always_comb begin
    for (int i = 0; i < int'(N); i++) begin
      blocked[i] = 1'b0;
      for (int j = 0; j < int'(N); j++) begin
        blocked[i] = blocked[i] | (cand_i[j] & older_i[j*N+i]);
      end
      grant_o[i] = cand_i[i] & ~blocked[i];
    end
  end
endmodule

// File: rtl/unified_rs.sv
module unified_rs #(
  parameter int unsigned N_ENT  = 8,
  parameter int unsigned OP_W   = 4,
  parameter int unsigned TAG_W  = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_BC   = 2,
  localparam int unsigned N_UT  = urs_pkg::NUM_UNIT_TYPES,
  localparam int unsigned CNT_W = $clog2(N_ENT + 1)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         flush_i,
  input  logic                         issue_valid_i,
  input  logic [OP_W-1:0]              issue_op_i,
  input  logic [TAG_W-1:0]             issue_tag_i,
  input  logic [1:0]                   issue_src_rdy_i,
  input  logic [1:0][TAG_W-1:0]        issue_src_tag_i,
  input  logic [1:0][DATA_W-1:0]       issue_src_val_i,
  input  logic                         rob_free_i,
  output logic                         issue_ready_o,
  input  logic [N_BC-1:0]              bc_valid_i,
  input  logic [N_BC-1:0][TAG_W-1:0]   bc_tag_i,
  input  logic [N_BC-1:0][DATA_W-1:0]  bc_data_i,
  input  logic [N_UT-1:0]              unit_free_i,
  output logic [N_UT-1:0]              disp_valid_o,
  output logic [N_UT-1:0][OP_W-1:0]    disp_op_o,
  output logic [N_UT-1:0][TAG_W-1:0]   disp_tag_o,
  output logic [N_UT-1:0][DATA_W-1:0]  disp_a_o,
  output logic [N_UT-1:0][DATA_W-1:0]  disp_b_o,
  output logic [CNT_W-1:0]             free_cnt_o
);
  logic [N_ENT-1:0]           ent_valid, ent_ready, ent_clear;
  logic [OP_W-1:0]            ent_op   [N_ENT];
  logic [TAG_W-1:0]           ent_tag  [N_ENT];
  logic [1:0][DATA_W-1:0]     ent_opnd [N_ENT];
  logic [N_ENT-1:0]           free_oh, alloc_vec;
  logic                       any_free, accept;
  logic [N_ENT*N_ENT-1:0]     older;
  logic [N_UT-1:0][N_ENT-1:0] grant, clr_by;

  // lowest-index empty entry takes the next issue
  always_comb begin
    free_oh  = '0;
    any_free = 1'b0;
    for (int i = 0; i < int'(N_ENT); i++) begin
      if (!ent_valid[i] && !any_free) begin
        free_oh[i] = 1'b1;
        any_free   = 1'b1;
      end
    end
  end

  assign issue_ready_o = any_free & rob_free_i;
  assign accept        = issue_valid_i & issue_ready_o & ~flush_i;
  assign alloc_vec     = free_oh & {N_ENT{accept}};

  always_comb begin
    free_cnt_o = '0;
    for (int i = 0; i < int'(N_ENT); i++) begin
      free_cnt_o = free_cnt_o + CNT_W'(!ent_valid[i]);
    end
  end

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    urs_entry #(
      .OP_W(OP_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .N_BC(N_BC)
    ) u_ent (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .flush_i    (flush_i),
      .alloc_i    (alloc_vec[i]),
      .clear_i    (ent_clear[i]),
      .op_i       (issue_op_i),
      .tag_i      (issue_tag_i),
      .src_rdy_i  (issue_src_rdy_i),
      .src_tag_i  (issue_src_tag_i),
      .src_val_i  (issue_src_val_i),
      .bc_valid_i (bc_valid_i),
      .bc_tag_i   (bc_tag_i),
      .bc_data_i  (bc_data_i),
      .valid_o    (ent_valid[i]),
      .ready_o    (ent_ready[i]),
      .op_o       (ent_op[i]),
      .tag_o      (ent_tag[i]),
      .opnd_o     (ent_opnd[i])
    );
  end

  urs_age #(.N(N_ENT)) u_age (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .alloc_i (alloc_vec),
    .older_o (older)
  );

  for (genvar t = 0; t < N_UT; t++) begin : g_type
    localparam logic TSEL = 1'(t);
    logic [N_ENT-1:0] cand;

    always_comb begin
      for (int i = 0; i < int'(N_ENT); i++) begin
        cand[i] = ent_ready[i] & (ent_op[i][OP_W-1] == TSEL);
      end
    end

    urs_pick #(.N(N_ENT)) u_pick (
      .cand_i  (cand),
      .older_i (older),
      .grant_o (grant[t])
    );

    assign disp_valid_o[t] = (|grant[t]) & unit_free_i[t] & ~flush_i;
    assign clr_by[t]       = grant[t] & {N_ENT{disp_valid_o[t]}};

    always_comb begin
      disp_op_o[t]  = '0;
      disp_tag_o[t] = '0;
      disp_a_o[t]   = '0;
      disp_b_o[t]   = '0;
      for (int i = 0; i < int'(N_ENT); i++) begin
        if (grant[t][i]) begin
          disp_op_o[t]  = disp_op_o[t]  | ent_op[i];
          disp_tag_o[t] = disp_tag_o[t] | ent_tag[i];
          disp_a_o[t]   = disp_a_o[t]   | ent_opnd[i][0];
          disp_b_o[t]   = disp_b_o[t]   | ent_opnd[i][1];
        end
      end
    end
  end

  always_comb begin
    ent_clear = '0;
    for (int t = 0; t < int'(N_UT); t++) ent_clear = ent_clear | clr_by[t];
  end
endmodule

module unified_rs_sva #(
  parameter int unsigned N_ENT = 8,
  parameter int unsigned N_UT  = 2,
  parameter int unsigned CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             flush_i,
  input logic             issue_valid_i,
  input logic             rob_free_i,
  input logic             issue_ready_o,
  input logic [N_UT-1:0]  unit_free_i,
  input logic [N_UT-1:0]  disp_valid_o,
  input logic [CNT_W-1:0] free_cnt_o
);
  logic acc;
  assign acc = issue_valid_i & issue_ready_o & ~flush_i;

  for (genvar t = 0; t < N_UT; t++) begin : g_t
    assert_disp_needs_unit_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      disp_valid_o[t] |-> unit_free_i[t]);
    assert_no_disp_in_flush_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_i |-> !disp_valid_o[t]);
  end

  assert_issue_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_ready_o |-> (rob_free_i && free_cnt_o != '0));

  assert_issue_open_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rob_free_i && free_cnt_o != '0) |-> issue_ready_o);

  assert_flush_empties_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> free_cnt_o == CNT_W'(N_ENT));

  assert_count_bound_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    free_cnt_o <= CNT_W'(N_ENT));

  assert_count_track_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i |=> int'(free_cnt_o) ==
      int'($past(free_cnt_o)) - int'($past(acc)) + int'($past($countones(disp_valid_o))));
endmodule

bind unified_rs unified_rs_sva #(.N_ENT(N_ENT), .N_UT(N_UT), .CNT_W(CNT_W)) u_sva (.*);

// File: tb/unified_rs_test.sv
module unified_rs_test;
  localparam int CLK_P = 10;
  localparam int HALF  = CLK_P / 2;

  typedef struct packed {
    logic [3:0]  op;
    logic [3:0]  tag;
    logic [31:0] a;
    logic [31:0] b;
  } item_t;

  logic             clk_i = 1'b0;
  logic             rst_ni;
  logic             flush_i;
  logic             issue_valid_i;
  logic [3:0]       issue_op_i;
  logic [3:0]       issue_tag_i;
  logic [1:0]       issue_src_rdy_i;
  logic [1:0][3:0]  issue_src_tag_i;
  logic [1:0][31:0] issue_src_val_i;
  logic             rob_free_i;
  logic             issue_ready_o;
  logic [1:0]       bc_valid_i;
  logic [1:0][3:0]  bc_tag_i;
  logic [1:0][31:0] bc_data_i;
  logic [1:0]       unit_free_i;
  logic [1:0]       disp_valid_o;
  logic [1:0][3:0]  disp_op_o;
  logic [1:0][3:0]  disp_tag_o;
  logic [1:0][31:0] disp_a_o;
  logic [1:0][31:0] disp_b_o;
  logic [3:0]       free_cnt_o;

  item_t q_exp [2][$];
  int n_chk = 0;
  int n_fail = 0;
  int both_cnt = 0;

  always #(HALF) clk_i = ~clk_i;

  unified_rs uut (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [71:0] act, input logic [71:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic do_issue(input logic [3:0] op, input logic [3:0] tag,
                          input bit r0, input logic [31:0] x0,
                          input bit r1, input logic [31:0] x1,
                          input logic [31:0] ea, input logic [31:0] eb, input bit push);
    issue_valid_i      = 1'b1;
    issue_op_i         = op;
    issue_tag_i        = tag;
    issue_src_rdy_i    = {r1, r0};
    issue_src_val_i[0] = r0 ? x0 : 32'h0;
    issue_src_val_i[1] = r1 ? x1 : 32'h0;
    issue_src_tag_i[0] = r0 ? 4'h0 : x0[3:0];
    issue_src_tag_i[1] = r1 ? 4'h0 : x1[3:0];
    if (push) q_exp[op[3]].push_back('{op: op, tag: tag, a: ea, b: eb});
    @(negedge clk_i);
    issue_valid_i = 1'b0;
  endtask

  // scoreboard monitor: samples one time unit before each rising edge
  initial begin
    forever begin
      @(negedge clk_i);
      #(HALF - 1);
      if (rst_ni) begin
        if (disp_valid_o == 2'b11) both_cnt++;
        for (int t = 0; t < 2; t++) begin
          if (disp_valid_o[t]) begin
            if (q_exp[t].size() == 0) begin
              check(1'b0, "R3", $sformatf("unexpected dispatch type %0d tag", t),
                    72'(disp_tag_o[t]), 72'h0);
            end else begin
              item_t e;
              item_t a;
              e = q_exp[t].pop_front();
              a = '{op: disp_op_o[t], tag: disp_tag_o[t], a: disp_a_o[t], b: disp_b_o[t]};
              check(a == e, "R3/R6/R8", $sformatf("dispatch type %0d {op,tag,a,b}", t),
                    72'(a), 72'(e));
            end
          end
        end
      end
    end
  end

  initial begin
    #(CLK_P * 20000);
    check(1'b0, "watchdog", "run did not finish", 72'h0, 72'h1);
    summary();
  end

  initial begin
    rst_ni = 1'b0; flush_i = 1'b0; issue_valid_i = 1'b0;
    issue_op_i = '0; issue_tag_i = '0; issue_src_rdy_i = '0;
    issue_src_tag_i = '0; issue_src_val_i = '0;
    rob_free_i = 1'b1; bc_valid_i = '0; bc_tag_i = '0; bc_data_i = '0;
    unit_free_i = 2'b11;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    // R1: empty after reset
    check(free_cnt_o == 4'd8, "R1", "free count", 72'(free_cnt_o), 72'd8);
    check(disp_valid_o == 2'b00, "R1", "dispatch idle", 72'(disp_valid_o), 72'h0);
    check(issue_ready_o == 1'b1, "R1", "issue ready", 72'(issue_ready_o), 72'h1);
    @(negedge clk_i);

    // R3, R6: ready operands, one add then one multiply
    do_issue(4'h1, 4'h1, 1, 32'd10, 1, 32'd20, 32'd10, 32'd20, 1);
    do_issue(4'h9, 4'h2, 1, 32'd3,  1, 32'd4,  32'd3,  32'd4,  1);
    repeat (2) @(negedge clk_i);
    #1;
    check(free_cnt_o == 4'd8, "R9", "freed without broadcast", 72'(free_cnt_o), 72'd8);

    // R2, R7, R9, R11: fill all entries with units busy
    unit_free_i = 2'b00;
    for (int k = 0; k < 8; k++) begin
      logic [3:0] op;
      op = (k % 2 == 0) ? 4'h2 : 4'hA;
      do_issue(op, 4'(k + 1), 1, 32'(k * 16), 1, 32'(k), 32'(k * 16), 32'(k), 1);
    end
    #1;
    check(free_cnt_o == 4'd0, "R11", "full count", 72'(free_cnt_o), 72'd0);
    check(issue_ready_o == 1'b0, "R2", "ready low when full", 72'(issue_ready_o), 72'h0);
    check(disp_valid_o == 2'b00, "R7", "no dispatch while busy", 72'(disp_valid_o), 72'h0);
    // offered while full: must be dropped
    do_issue(4'h3, 4'hF, 1, 32'hDEAD, 1, 32'hBEEF, 0, 0, 0);
    #1;
    check(free_cnt_o == 4'd0, "R2", "full issue dropped", 72'(free_cnt_o), 72'd0);
    unit_free_i = 2'b11;
    @(negedge clk_i);
    #1;
    check(free_cnt_o == 4'd2, "R9", "two released per cycle", 72'(free_cnt_o), 72'd2);
    repeat (4) @(negedge clk_i);
    #1;
    check(free_cnt_o == 4'd8, "R11", "drained count", 72'(free_cnt_o), 72'd8);
    check(both_cnt >= 4, "R7", "cycles with both types dispatching", 72'(both_cnt), 72'd4);

    // R2: reorder buffer full blocks issue
    rob_free_i = 1'b0;
    #1;
    check(issue_ready_o == 1'b0, "R2", "ready low without rob slot", 72'(issue_ready_o), 72'h0);
    do_issue(4'h3, 4'hE, 1, 32'h1, 1, 32'h2, 0, 0, 0);
    #1;
    check(free_cnt_o == 4'd8, "R2", "rob-blocked issue dropped", 72'(free_cnt_o), 72'd8);
    rob_free_i = 1'b1;
    @(negedge clk_i);

    // R4: capture one cycle after issue, wrong tag ignored
    do_issue(4'h2, 4'h3, 0, 32'hA, 1, 32'd7, 32'h55, 32'd7, 1);
    #1;
    check(disp_valid_o[0] == 1'b0, "R4", "waiting operand blocks", 72'(disp_valid_o[0]), 72'h0);
    @(negedge clk_i);
    bc_valid_i = 2'b10; bc_tag_i[1] = 4'hB; bc_data_i[1] = 32'h99;
    @(negedge clk_i);
    bc_tag_i[1] = 4'hA; bc_data_i[1] = 32'h55;
    #1;
    check(disp_valid_o[0] == 1'b0, "R4", "wrong tag ignored / no same-cycle dispatch",
          72'(disp_valid_o[0]), 72'h0);
    @(negedge clk_i);
    bc_valid_i = 2'b00;
    #1;
    check(disp_valid_o[0] == 1'b1, "R4", "dispatch after capture", 72'(disp_valid_o[0]), 72'h1);
    repeat (2) @(negedge clk_i);

    // R5: broadcast in the issue cycle
    bc_valid_i = 2'b11;
    bc_tag_i[0] = 4'hD; bc_data_i[0] = 32'h111;
    bc_tag_i[1] = 4'hE; bc_data_i[1] = 32'h222;
    do_issue(4'hC, 4'h4, 0, 32'hD, 0, 32'hE, 32'h111, 32'h222, 1);
    bc_valid_i = 2'b00;
    #1;
    check(disp_valid_o[1] == 1'b1, "R5", "issue-cycle broadcast captured", 72'(disp_valid_o[1]), 72'h1);
    repeat (2) @(negedge clk_i);

    // R8: older entry becomes ready after younger; older goes first
    unit_free_i = 2'b10;
    do_issue(4'h5, 4'h6, 0, 32'h7, 1, 32'd1, 32'h70, 32'd1, 1);
    do_issue(4'h6, 4'h7, 1, 32'd5, 1, 32'd6, 32'd5, 32'd6, 1);
    bc_valid_i = 2'b01; bc_tag_i[0] = 4'h7; bc_data_i[0] = 32'h70;
    @(negedge clk_i);
    bc_valid_i = 2'b00;
    unit_free_i = 2'b11;
    #1;
    check(disp_tag_o[0] == 4'h6, "R8", "oldest ready first", 72'(disp_tag_o[0]), 72'h6);
    repeat (3) @(negedge clk_i);

    // R10: flush drops entries and the same-cycle issue
    unit_free_i = 2'b00;
    do_issue(4'h1, 4'h8, 1, 32'd1, 1, 32'd2, 0, 0, 0);
    do_issue(4'h9, 4'h9, 0, 32'h3, 1, 32'd2, 0, 0, 0);
    unit_free_i = 2'b11;
    flush_i = 1'b1;
    issue_valid_i = 1'b1; issue_op_i = 4'h1; issue_tag_i = 4'hA;
    issue_src_rdy_i = 2'b11;
    #1;
    check(disp_valid_o == 2'b00, "R10", "no dispatch during flush", 72'(disp_valid_o), 72'h0);
    @(negedge clk_i);
    flush_i = 1'b0; issue_valid_i = 1'b0;
    #1;
    check(free_cnt_o == 4'd8, "R10", "all empty after flush", 72'(free_cnt_o), 72'd8);
    bc_valid_i = 2'b01; bc_tag_i[0] = 4'h3; bc_data_i[0] = 32'h5;
    @(negedge clk_i);
    bc_valid_i = 2'b00;
    repeat (3) @(negedge clk_i);

    check(q_exp[0].size() == 0, "R3", "add items outstanding", 72'(q_exp[0].size()), 72'h0);
    check(q_exp[1].size() == 0, "R3", "mul items outstanding", 72'(q_exp[1].size()), 72'h0);
    summary();
  end
endmodule